// File: doc/BRIEF.md
# Memory Operation Queue with Store-to-Load Forwarding

This block keeps a core's loads and stores in program order from dispatch to retirement. Each operation takes a slot when it is allocated. A separate address-generation step fills in the slot's word address, byte enables, store data and a translation-miss flag later. Every cycle the block compares each pending load with all stores that are older than it. A load waits while any older store still has no address. It takes its data straight from the nearest older store to the same word when that store supplies every byte the load needs. Otherwise it goes to the data cache.

Stores never write the cache early. A store writes the cache only from the head of the queue, when the core permits retirement, and the head stays in place until the cache accepts the write. An entry that was flagged with a translation miss spends a fixed number of cycles at the head before it may retire. This models a miss that is serviced at retirement time.

Top module: `lsq_mem_sched`

## Requirements
- R1: `alloc_ready` is low exactly when DEPTH entries are held. Slots are handed out through `alloc_idx` in ascending order, modulo DEPTH, starting from 0 after reset.
- R2: A load with a known address neither issues nor forwards while any older store in the queue has no address yet. It is evaluated again in every later cycle.
- R3: When the nearest older store to the same word covers all of the load's byte enables, the load forwards. `fwd_valid` pulses with `fwd_data` equal to that store's data, and no cache request is made for that load.
- R4: A load with no older store to its word and no older store lacking an address is presented on `ld_req_*` with its word address and byte enables.
- R5: When several older stores hit the load's word, `fwd_src` names the youngest of them.
- R6: When the nearest older same-word store lacks any of the load's enabled bytes, the load stalls. It neither forwards nor requests the cache.
- R7: At most one load acts per cycle, by forwarding or by cache request, and it is the oldest load able to act. A cache request counts as done only in a cycle with `ld_req_ready` high.
- R8: `st_wr_valid` is asserted only for a store at the head with a known address while `commit_en` is high. The store retires only when `st_wr_ready` is also high. Loads never write the cache.
- R9: An entry flagged with a translation miss retires no earlier than TLB_LAT cycles after it stands at the head with the flag set. The head's entries retire in order, and a load retires only after it has acted.
- R10: After reset the queue is empty. No load request, forward, cache write or retirement is signalled, and `alloc_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate the next slot in program order |
| alloc_store | input | 1 | 1 = the new entry is a store, 0 = a load |
| alloc_ready | output | 1 | A free slot exists |
| alloc_idx | output | IW | Slot that the allocation takes |
| agen_valid | input | 1 | Address generation result for one entry |
| agen_idx | input | IW | Slot being completed |
| agen_word | input | AW | Word address |
| agen_bytes | input | DW/8 | Byte enables within the word |
| agen_data | input | DW | Store data (unused for loads) |
| agen_tlb_miss | input | 1 | Translation missed for this entry |
| commit_en | input | 1 | Core allows the head to retire this cycle |
| ld_req_valid | output | 1 | Load request to the data cache |
| ld_req_ready | input | 1 | Cache accepts the load request |
| ld_req_idx | output | IW | Slot of the requesting load |
| ld_req_word | output | AW | Word address of the request |
| ld_req_bytes | output | DW/8 | Byte enables of the request |
| fwd_valid | output | 1 | A load is served from an older store |
| fwd_idx | output | IW | Slot of the forwarded load |
| fwd_src | output | IW | Slot of the store supplying the data |
| fwd_data | output | DW | Forwarded store data |
| st_wr_valid | output | 1 | Head store writes the data cache |
| st_wr_ready | input | 1 | Cache accepts the store write |
| st_wr_word | output | AW | Word address of the write |
| st_wr_bytes | output | DW/8 | Byte enables of the write |
| st_wr_data | output | DW | Store data |
| retire_valid | output | 1 | Head entry leaves the queue |

## Verification
Two of the block's functions can land in the same cycle, and that overlap is the delicate point. A store at the head may be writing the cache and retiring in the very cycle that a younger load forwards from it. Likewise, an older store's address may arrive in the same cycle in which a younger load is being judged. In that case the load must still stall that cycle and act only on the next one. Both overlaps arise often from random stimulus that draws addresses from a pool of four words and enables retirement and address generation in biased phases. Every output is then judged on every clock against a behavioural model that keeps entries in an age-ordered queue.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

    // What the selected load does this cycle.
    typedef enum logic [1:0] {
        LD_NONE  = 2'd0,
        LD_CACHE = 2'd1,
        LD_FWD   = 2'd2
    } ld_act_e;

endpackage

// File: rtl/lsq_disambig.sv
module lsq_disambig
    import lsq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 12,
    parameter int BW    = 4,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic [IW-1:0]             head,
    input  logic [DEPTH-1:0]          vld,
    input  logic [DEPTH-1:0]          st,
    input  logic [DEPTH-1:0]          known,
    input  logic [DEPTH-1:0]          done,
    input  logic [DEPTH-1:0][AW-1:0]  word,
    input  logic [DEPTH-1:0][BW-1:0]  bytes,
    output ld_act_e                   act,
    output logic [IW-1:0]             sel,
    output logic [IW-1:0]             src
);

    logic [DEPTH-1:0]          elig;
    logic [DEPTH-1:0]          hit;
    logic [DEPTH-1:0][IW-1:0]  src_of;

    // One comparator chain per slot: scan older stores from oldest to youngest.
    for (genvar j = 0; j < DEPTH; j++) begin : g_ld
        logic [IW-1:0] age_j;
        logic          blk_j;
        logic          hit_j;
        logic [IW-1:0] src_j;

        assign age_j = IW'(j) - head;

        always_comb begin
            logic [IW-1:0] slot;
            blk_j = 1'b0;
            hit_j = 1'b0;
            src_j = '0;
            for (int k = 0; k < DEPTH; k++) begin
                slot = head + IW'(k);
                if (IW'(k) < age_j && vld[slot] && st[slot]) begin
                    if (!known[slot]) begin
                        blk_j = 1'b1;
                    end else if (word[slot] == word[j]) begin
                        hit_j = 1'b1;
                        src_j = slot;
                    end
                end
            end
            if (hit_j && ((bytes[src_j] & bytes[j]) != bytes[j])) begin
                blk_j = 1'b1;
            end
        end

        assign elig[j]   = vld[j] & ~st[j] & known[j] & ~done[j] & ~blk_j;
        assign hit[j]    = hit_j;
        assign src_of[j] = src_j;
    end

    // Oldest eligible load wins: walk youngest to oldest, last write stays.
    logic found;
    always_comb begin
        logic [IW-1:0] slot;
        found = 1'b0;
        sel   = '0;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            slot = head + IW'(k);
            if (elig[slot]) begin
                found = 1'b1;
                sel   = slot;
            end
        end
    end

    assign act = !found ? LD_NONE : (hit[sel] ? LD_FWD : LD_CACHE);
    assign src = src_of[sel];

endmodule

// File: rtl/lsq_commit.sv
module lsq_commit #(
    parameter int TLB_LAT = 3,
    localparam int TCW    = $clog2(TLB_LAT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic head_vld,
    input  logic head_st,
    input  logic head_ready,
    input  logic head_tlb,
    input  logic commit_en,
    input  logic wr_ready,
    output logic wr_valid,
    output logic retire
);

    typedef struct packed {
        logic [TCW-1:0] wait_cnt;
    } cmt_state_t;

    cmt_state_t c_q, c_d;
    logic       tlb_ok;
    logic       may_go;

    assign tlb_ok   = !head_tlb || (c_q.wait_cnt == TCW'(TLB_LAT));
    assign may_go   = head_vld && commit_en && head_ready && tlb_ok;
    assign wr_valid = may_go && head_st;
    assign retire   = may_go && (!head_st || wr_ready);

    always_comb begin
        c_d = c_q;
        if (retire) begin
            c_d.wait_cnt = '0;
        end else if (head_vld && head_tlb && c_q.wait_cnt != TCW'(TLB_LAT)) begin
            c_d.wait_cnt = c_q.wait_cnt + TCW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

endmodule

// File: rtl/lsq_mem_sched.sv
module lsq_mem_sched
    import lsq_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int AW      = 12,
    parameter int DW      = 32,
    parameter int TLB_LAT = 3,
    localparam int BW     = DW / 8,
    localparam int IW     = $clog2(DEPTH),
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_valid,
    input  logic          alloc_store,
    output logic          alloc_ready,
    output logic [IW-1:0] alloc_idx,
    input  logic          agen_valid,
    input  logic [IW-1:0] agen_idx,
    input  logic [AW-1:0] agen_word,
    input  logic [BW-1:0] agen_bytes,
    input  logic [DW-1:0] agen_data,
    input  logic          agen_tlb_miss,
    input  logic          commit_en,
    output logic          ld_req_valid,
    input  logic          ld_req_ready,
    output logic [IW-1:0] ld_req_idx,
    output logic [AW-1:0] ld_req_word,
    output logic [BW-1:0] ld_req_bytes,
    output logic          fwd_valid,
    output logic [IW-1:0] fwd_idx,
    output logic [IW-1:0] fwd_src,
    output logic [DW-1:0] fwd_data,
    output logic          st_wr_valid,
    input  logic          st_wr_ready,
    output logic [AW-1:0] st_wr_word,
    output logic [BW-1:0] st_wr_bytes,
    output logic [DW-1:0] st_wr_data,
    output logic          retire_valid
);

    typedef struct packed {
        logic [DEPTH-1:0]          vld;
        logic [DEPTH-1:0]          st;
        logic [DEPTH-1:0]          known;
        logic [DEPTH-1:0]          tlb;
        logic [DEPTH-1:0]          done;
        logic [DEPTH-1:0][AW-1:0]  word;
        logic [DEPTH-1:0][BW-1:0]  bytes;
        logic [DEPTH-1:0][DW-1:0]  data;
        logic [IW-1:0]             head;
        logic [IW-1:0]             tail;
        logic [CW-1:0]             cnt;
    } lsq_state_t;

    lsq_state_t s_q, s_d;

    ld_act_e       act;
    logic [IW-1:0] sel;
    logic [IW-1:0] src;
    logic          alloc_fire;
    logic          ld_fire;
    logic          head_ready;
    logic          retire;

    lsq_disambig #(.DEPTH(DEPTH), .AW(AW), .BW(BW)) u_disambig (
        .head  (s_q.head),
        .vld   (s_q.vld),
        .st    (s_q.st),
        .known (s_q.known),
        .done  (s_q.done),
        .word  (s_q.word),
        .bytes (s_q.bytes),
        .act   (act),
        .sel   (sel),
        .src   (src)
    );

    assign head_ready = s_q.st[s_q.head] ? s_q.known[s_q.head] : s_q.done[s_q.head];

    lsq_commit #(.TLB_LAT(TLB_LAT)) u_commit (
        .clk        (clk),
        .rst_n      (rst_n),
        .head_vld   (s_q.vld[s_q.head]),
        .head_st    (s_q.st[s_q.head]),
        .head_ready (head_ready),
        .head_tlb   (s_q.tlb[s_q.head]),
        .commit_en  (commit_en),
        .wr_ready   (st_wr_ready),
        .wr_valid   (st_wr_valid),
        .retire     (retire)
    );

    assign alloc_ready  = (s_q.cnt != CW'(DEPTH));
    assign alloc_idx    = s_q.tail;
    assign alloc_fire   = alloc_valid && alloc_ready;
    assign ld_fire      = (act == LD_FWD) || (act == LD_CACHE && ld_req_ready);

    assign ld_req_valid = (act == LD_CACHE);
    assign ld_req_idx   = sel;
    assign ld_req_word  = s_q.word[sel];
    assign ld_req_bytes = s_q.bytes[sel];

    assign fwd_valid    = (act == LD_FWD);
    assign fwd_idx      = sel;
    assign fwd_src      = src;
    assign fwd_data     = s_q.data[src];

    assign st_wr_word   = s_q.word[s_q.head];
    assign st_wr_bytes  = s_q.bytes[s_q.head];
    assign st_wr_data   = s_q.data[s_q.head];
    assign retire_valid = retire;

    always_comb begin
        s_d = s_q;
        if (retire) begin
            s_d.vld[s_q.head] = 1'b0;
            s_d.head          = s_q.head + IW'(1);
        end
        if (alloc_fire) begin
            s_d.vld[s_q.tail]   = 1'b1;
            s_d.st[s_q.tail]    = alloc_store;
            s_d.known[s_q.tail] = 1'b0;
            s_d.tlb[s_q.tail]   = 1'b0;
            s_d.done[s_q.tail]  = 1'b0;
            s_d.tail            = s_q.tail + IW'(1);
        end
        if (agen_valid && s_q.vld[agen_idx]) begin
            s_d.known[agen_idx] = 1'b1;
            s_d.word[agen_idx]  = agen_word;
            s_d.bytes[agen_idx] = agen_bytes;
            s_d.data[agen_idx]  = agen_data;
            s_d.tlb[agen_idx]   = agen_tlb_miss;
        end
        if (ld_fire) begin
            s_d.done[sel] = 1'b1;
        end
        s_d.cnt = s_q.cnt + CW'(alloc_fire) - CW'(retire);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/lsq_mem_sched_chk.sv
module lsq_mem_sched_chk #(
    parameter int DEPTH = 8,
    parameter int IW    = 3,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          alloc_valid,
    input logic          alloc_ready,
    input logic          commit_en,
    input logic          retire_valid,
    input logic          ld_req_valid,
    input logic          fwd_valid,
    input logic [IW-1:0] fwd_idx,
    input logic [IW-1:0] fwd_src,
    input logic          st_wr_valid,
    input logic          st_wr_ready
);

    logic [CW-1:0] occ_q;

    always_ff @(posedge clk) begin
        if (!rst_n) occ_q <= '0;
        else        occ_q <= occ_q + CW'(alloc_valid && alloc_ready) - CW'(retire_valid);
    end

    a_r1_ready_tracks_occupancy: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_ready == (occ_q < CW'(DEPTH)));

    a_r7_one_load_action: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_req_valid && fwd_valid));

    a_r3_source_is_other_slot: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> fwd_src != fwd_idx);

    a_r8_write_needs_commit: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr_valid |-> commit_en);

    a_r8_store_waits_for_cache: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr_valid && !st_wr_ready) |-> !retire_valid);

    a_r10_empty_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q == '0) |-> (!retire_valid && !ld_req_valid && !fwd_valid && !st_wr_valid));

endmodule

bind lsq_mem_sched lsq_mem_sched_chk #(.DEPTH(DEPTH), .IW(IW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_valid  (alloc_valid),
    .alloc_ready  (alloc_ready),
    .commit_en    (commit_en),
    .retire_valid (retire_valid),
    .ld_req_valid (ld_req_valid),
    .fwd_valid    (fwd_valid),
    .fwd_idx      (fwd_idx),
    .fwd_src      (fwd_src),
    .st_wr_valid  (st_wr_valid),
    .st_wr_ready  (st_wr_ready)
);

// File: tb/lsq_mem_sched_tb_top.sv
module lsq_mem_sched_tb_top;

    localparam int D   = 8;
    localparam int AW  = 12;
    localparam int DW  = 32;
    localparam int BW  = DW / 8;
    localparam int IW  = 3;
    localparam int LAT = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n;
    logic          alloc_valid, alloc_store, alloc_ready;
    logic [IW-1:0] alloc_idx;
    logic          agen_valid;
    logic [IW-1:0] agen_idx;
    logic [AW-1:0] agen_word;
    logic [BW-1:0] agen_bytes;
    logic [DW-1:0] agen_data;
    logic          agen_tlb_miss;
    logic          commit_en;
    logic          ld_req_valid, ld_req_ready;
    logic [IW-1:0] ld_req_idx;
    logic [AW-1:0] ld_req_word;
    logic [BW-1:0] ld_req_bytes;
    logic          fwd_valid;
    logic [IW-1:0] fwd_idx, fwd_src;
    logic [DW-1:0] fwd_data;
    logic          st_wr_valid, st_wr_ready;
    logic [AW-1:0] st_wr_word;
    logic [BW-1:0] st_wr_bytes;
    logic [DW-1:0] st_wr_data;
    logic          retire_valid;

    lsq_mem_sched #(.DEPTH(D), .AW(AW), .DW(DW), .TLB_LAT(LAT)) dut_i (.*);

    int checks = 0;
    int errors = 0;

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Behavioural model: slots listed oldest first in a queue.
    int          order[$];
    bit          m_st[D], m_known[D], m_tlb[D], m_done[D];
    int          m_word[D], m_bytes[D];
    logic [31:0] m_data[D];
    int          m_tail = 0;
    int          m_tcnt = 0;

    bit e_ready, e_wr, e_ret;
    int e_sel, e_src;

    int n_full = 0, n_wait_addr = 0, n_partial = 0, n_fwd = 0, n_multi = 0;
    int n_tlb_wait = 0, n_wr_stall = 0, n_req = 0;

    task automatic model_eval();
        e_ready = order.size() < D;
        if (!e_ready) n_full++;
        e_sel = -1;
        e_src = -1;
        for (int p = 0; p < order.size(); p++) begin
            int  s;
            bit  blk;
            int  near;
            int  hits;
            s = order[p];
            if (!m_st[s] && m_known[s] && !m_done[s]) begin
                blk = 0; near = -1; hits = 0;
                for (int q = 0; q < p; q++) begin
                    int o;
                    o = order[q];
                    if (m_st[o]) begin
                        if (!m_known[o]) blk = 1;
                        else if (m_word[o] == m_word[s]) begin near = o; hits++; end
                    end
                end
                if (blk) n_wait_addr++;
                if (!blk && near >= 0 && ((m_bytes[near] & m_bytes[s]) != m_bytes[s])) begin
                    blk = 1;
                    n_partial++;
                end
                if (!blk) begin
                    e_sel = s;
                    e_src = near;
                    if (near >= 0) begin n_fwd++; if (hits > 1) n_multi++; end
                    else n_req++;
                    break;
                end
            end
        end
        e_wr = 0;
        e_ret = 0;
        if (order.size() > 0) begin
            int h;
            bit rdy, tok;
            h   = order[0];
            rdy = m_st[h] ? m_known[h] : m_done[h];
            tok = !m_tlb[h] || (m_tcnt >= LAT);
            if (m_tlb[h] && !tok && commit_en && rdy) n_tlb_wait++;
            e_wr  = m_st[h] && commit_en && rdy && tok;
            e_ret = commit_en && rdy && tok && (!m_st[h] || st_wr_ready);
            if (e_wr && !st_wr_ready) n_wr_stall++;
        end
    endtask

    task automatic compare();
        chk("R1", "alloc_ready", alloc_ready, e_ready);
        if (e_ready) chk("R1", "alloc_idx", alloc_idx, m_tail);
        chk("R2", "ld_req_valid", ld_req_valid, (e_sel >= 0 && e_src < 0));
        chk("R3", "fwd_valid", fwd_valid, (e_sel >= 0 && e_src >= 0));
        if (e_sel >= 0 && e_src < 0 && ld_req_valid) begin
            chk("R7", "ld_req_idx", ld_req_idx, e_sel);
            chk("R4", "ld_req_word", ld_req_word, m_word[e_sel]);
            chk("R4", "ld_req_bytes", ld_req_bytes, m_bytes[e_sel]);
        end
        if (e_sel >= 0 && e_src >= 0 && fwd_valid) begin
            chk("R7", "fwd_idx", fwd_idx, e_sel);
            chk("R5", "fwd_src", fwd_src, e_src);
            chk("R3", "fwd_data", fwd_data, m_data[e_src]);
        end
        chk("R8", "st_wr_valid", st_wr_valid, e_wr);
        if (e_wr && st_wr_valid) begin
            chk("R8", "st_wr_word", st_wr_word, m_word[order[0]]);
            chk("R8", "st_wr_data", st_wr_data, m_data[order[0]]);
        end
        chk("R9", "retire_valid", retire_valid, e_ret);
    endtask

    task automatic model_commit();
        if (e_ret) m_tcnt = 0;
        else if (order.size() > 0 && m_tlb[order[0]] && m_tcnt < LAT) m_tcnt++;
        if (e_ret) void'(order.pop_front());
        if (e_sel >= 0 && (e_src >= 0 || ld_req_ready)) m_done[e_sel] = 1;
        if (alloc_valid && e_ready) begin
            order.push_back(m_tail);
            m_st[m_tail]    = alloc_store;
            m_known[m_tail] = 0;
            m_tlb[m_tail]   = 0;
            m_done[m_tail]  = 0;
            m_tail          = (m_tail + 1) % D;
        end
        if (agen_valid) begin
            m_known[agen_idx] = 1;
            m_word[agen_idx]  = int'(agen_word);
            m_bytes[agen_idx] = int'(agen_bytes);
            m_data[agen_idx]  = agen_data;
            m_tlb[agen_idx]   = agen_tlb_miss;
        end
    endtask

    task automatic drive(int p_alloc, int p_agen, int p_commit);
        int cand[$];
        alloc_valid   = ($urandom % 100) < p_alloc;
        alloc_store   = $urandom % 2;
        agen_valid    = 0;
        agen_idx      = '0;
        agen_word     = AW'($urandom % 4);
        case ($urandom % 5)
            0: agen_bytes = 4'h3;
            1: agen_bytes = 4'hC;
            2: agen_bytes = 4'h1;
            default: agen_bytes = 4'hF;
        endcase
        agen_data     = $urandom;
        agen_tlb_miss = ($urandom % 8) == 0;
        foreach (order[i]) if (!m_known[order[i]]) cand.push_back(order[i]);
        if (cand.size() > 0 && ($urandom % 100) < p_agen) begin
            agen_valid = 1;
            agen_idx   = IW'(cand[$urandom % cand.size()]);
        end
        commit_en    = ($urandom % 100) < p_commit;
        ld_req_ready = ($urandom % 4) != 0;
        st_wr_ready  = ($urandom % 3) != 0;
    endtask

    task automatic run(int cycles, int p_alloc, int p_agen, int p_commit);
        for (int c = 0; c < cycles; c++) begin
            drive(p_alloc, p_agen, p_commit);
            #1;
            model_eval();
            compare();
            @(posedge clk);
            model_commit();
            @(negedge clk);
        end
    endtask

    initial begin
        rst_n = 0;
        alloc_valid = 0; alloc_store = 0; agen_valid = 0; agen_idx = '0;
        agen_word = '0; agen_bytes = '0; agen_data = '0; agen_tlb_miss = 0;
        commit_en = 0; ld_req_ready = 0; st_wr_ready = 0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        #1;
        // R10: empty and quiet straight after reset
        chk("R10", "alloc_ready", alloc_ready, 1);
        chk("R10", "alloc_idx", alloc_idx, 0);
        chk("R10", "ld_req_valid", ld_req_valid, 0);
        chk("R10", "fwd_valid", fwd_valid, 0);
        chk("R10", "st_wr_valid", st_wr_valid, 0);
        chk("R10", "retire_valid", retire_valid, 0);
        @(negedge clk);
        run(1500, 60, 50, 70);
        run(1000, 80, 60, 10);
        run(1000, 50, 15, 60);
        run(800, 40, 70, 90);
        // Each corner must have been reached by the stimulus.
        chk("R1", "full seen", n_full > 0, 1);
        chk("R2", "wait on unknown store seen", n_wait_addr > 0, 1);
        chk("R3", "forward seen", n_fwd > 0, 1);
        chk("R4", "cache request seen", n_req > 0, 1);
        chk("R5", "multi-match forward seen", n_multi > 0, 1);
        chk("R6", "partial stall seen", n_partial > 0, 1);
        chk("R8", "write stall seen", n_wr_stall > 0, 1);
        chk("R9", "translation wait seen", n_tlb_wait > 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule